// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block controls 32 general-purpose pins, grouped as four banks of eight. A host reaches it over a plain synchronous register port: an address, a write strobe, write data, and read data that follows the address within the same cycle. Each bank has its own window of registers. These hold the pin direction, the driven output value, the sampled input value, an interrupt mask, a sticky-mode selector and an interrupt status. The block does not drive pads itself. It presents an output-value vector and an output-enable vector for pad cells to use.

Pin inputs pass through a two-flop synchroniser before anything else sees them. Each pin's interrupt status works in one of two modes. In level mode, the status follows the synchronised pin level. In sticky mode, the status is captured on a rising edge and stays set until software clears it. Status bits that are not masked are combined into a single interrupt request line. Setting and clearing mask bits use separate write addresses, so software never needs a read-modify-write sequence.

Top module: `banked_gpio`

## Requirements
- R1: Address bits [7:6] select the bank, and bank k covers offsets k*0x40 to k*0x40+0x3F. Pin n sits in bank n>>3 at bit n&7 of every register of that bank. Register data occupies bits [7:0] of the data bus.
- R2: After reset, every direction bit is 1 (input), so every output enable is 0. Outputs are 0, all mask bits are 1, and the status, sticky and masked-status registers are 0. The interrupt line is low.
- R3: Bank offset 0x10 is a read/write direction register, where 1 means input and 0 means output. The output enable of a pin is 1 exactly when its direction bit is 0. Bank offset 0x14 is a read/write output register that drives the pin output vector.
- R4: Bank offset 0x18 is read-only and returns the synchronised pin levels. A pin change that is set up before a rising clock edge is not yet visible after that edge. It becomes readable after the second rising edge.
- R5: A read of bank offset 0x08 returns the mask. A write there sets the mask bits where the data holds 1s and leaves all other bits unchanged.
- R6: A write to bank offset 0x0C clears the mask bits where the data holds 1s. A read of 0x0C returns 0.
- R7: For a pin whose sticky bit is 0, the raw status read at bank offset 0x04 equals its synchronised level, and writes to 0x04 do not change it.
- R8: For a pin whose sticky bit is 1, the raw status bit is set by a rising edge of the synchronised level. It becomes readable after the third rising clock edge following the pin change, and it holds after the pin falls. Writing 1 to that bit at offset 0x04 clears it, and writing 0 leaves it unchanged.
- R9: A read of bank offset 0x20 returns the sticky configuration. A write there sets the bits where the data holds 1s, and 0s do not clear any bit.
- R10: Bank offset 0x00 is read-only and returns the raw status AND NOT the mask.
- R11: The interrupt output is the OR of all masked-status bits across the four banks.
- R12: Reads of any other offset return 0, and writes to such offsets change no state. Read data bits above bit 7 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte address of the register access |
| regWe | input | 1 | Write strobe for the current cycle |
| regWdata | input | 32 | Write data; bits [7:0] are used |
| regRdata | output | 32 | Read data for regAddr, valid in the same cycle |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Values to drive on the pins |
| pinOe | output | 32 | Output enable per pin, 1 = drive |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a sticky status bit that must hold after its pin has fallen. Clear writes can arrive around it that carry 0 in its position or 1s for neighbouring bits, and a new rising edge can land on the same cycle as a clear. A directed sequence steps one pin through rise, fall and partial clears, counting edges to the cycle in which the latch becomes visible. A long seeded random run then toggles pins while it scatters status-clear, sticky-set and mask writes across all banks, so that edges and clears coincide in many different alignments. Every read is compared with a bench model built from the requirements.

// File: rtl/banked_gpio_pkg.sv
package banked_gpio_pkg;
  localparam int unsigned BANKS      = 4;
  localparam int unsigned BANK_W     = 8;
  localparam int unsigned PINS       = BANKS * BANK_W;
  localparam int unsigned OFF_W      = 6;
  localparam int unsigned BANK_IDX_W = $clog2(BANKS);
  localparam int unsigned ADDR_W     = OFF_W + BANK_IDX_W;

  // offsets inside one bank window
  localparam logic [OFF_W-1:0] OFF_MSTAT  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_RSTAT  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_MSET   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_MCLR   = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_DIR    = 6'h10;
  localparam logic [OFF_W-1:0] OFF_OUT    = 6'h14;
  localparam logic [OFF_W-1:0] OFF_IN     = 6'h18;
  localparam logic [OFF_W-1:0] OFF_STICKY = 6'h20;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MSTAT, SEL_RSTAT, SEL_MASK,
    SEL_DIR, SEL_OUT, SEL_IN, SEL_STICKY
  } rdSel_e;

  typedef struct packed {
    logic [BANKS-1:0]      statClr;
    logic [BANKS-1:0]      maskSet;
    logic [BANKS-1:0]      maskClr;
    logic [BANKS-1:0]      dirWr;
    logic [BANKS-1:0]      outWr;
    logic [BANKS-1:0]      stickySet;
    rdSel_e                rdSel;
    logic [BANK_IDX_W-1:0] rdBank;
  } strobe_t;
endpackage

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
  import banked_gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output strobe_t           strb
);
  logic [OFF_W-1:0]      off;
  logic [BANK_IDX_W-1:0] bankIdx;
  logic [BANKS-1:0]      bankHot;
  logic [BANKS-1:0]      wrHot;

  assign off     = regAddr[OFF_W-1:0];
  assign bankIdx = regAddr[ADDR_W-1:OFF_W];
  assign bankHot = BANKS'(1) << bankIdx;
  assign wrHot   = regWe ? bankHot : '0;

  always_comb begin
    strb        = '0;
    strb.rdSel  = SEL_NONE;
    strb.rdBank = bankIdx;
    case (off)
      OFF_MSTAT:  strb.rdSel = SEL_MSTAT;
      OFF_RSTAT:  begin strb.rdSel = SEL_RSTAT;  strb.statClr   = wrHot; end
      OFF_MSET:   begin strb.rdSel = SEL_MASK;   strb.maskSet   = wrHot; end
      OFF_MCLR:   strb.maskClr = wrHot;
      OFF_DIR:    begin strb.rdSel = SEL_DIR;    strb.dirWr     = wrHot; end
      OFF_OUT:    begin strb.rdSel = SEL_OUT;    strb.outWr     = wrHot; end
      OFF_IN:     strb.rdSel = SEL_IN;
      OFF_STICKY: begin strb.rdSel = SEL_STICKY; strb.stickySet = wrHot; end
      default:    strb.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/banked_gpio_dp.sv
module banked_gpio_dp
  import banked_gpio_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [BANK_W-1:0]             wrByte,
  input  logic [PINS-1:0]               pinIn,
  output logic [BANK_W-1:0]             rdByte,
  output logic [PINS-1:0]               pinOut,
  output logic [PINS-1:0]               pinOe,
  output logic                          irqOut,
  output logic [BANKS-1:0][BANK_W-1:0]  maskState,
  output logic [BANKS-1:0][BANK_W-1:0]  latchState
);
  logic [PINS-1:0] syncA, syncB, prevQ;
  logic [BANKS-1:0][BANK_W-1:0] lvl, rise;
  logic [BANKS-1:0][BANK_W-1:0] dirQ, outQ, maskQ, stickyQ, latchQ;
  logic [BANKS-1:0][BANK_W-1:0] rawStat, maskedStat;

  // two-flop synchroniser plus one stage of history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign lvl  = syncB;
  assign rise = syncB & ~prevQ;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] dirR, outR, maskR, stickyR, latchR, clrBits;

    assign clrBits = strb.statClr[b] ? wrByte : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirR    <= '1;
        outR    <= '0;
        maskR   <= '1;
        stickyR <= '0;
        latchR  <= '0;
      end else begin
        if (strb.dirWr[b]) dirR <= wrByte;
        if (strb.outWr[b]) outR <= wrByte;
        if (strb.maskSet[b])      maskR <= maskR | wrByte;
        else if (strb.maskClr[b]) maskR <= maskR & ~wrByte;
        if (strb.stickySet[b]) stickyR <= stickyR | wrByte;
        // a fresh edge wins over a clear landing in the same cycle
        latchR <= ((latchR & ~clrBits) | rise[b]) & stickyR;
      end
    end

    assign dirQ[b]       = dirR;
    assign outQ[b]       = outR;
    assign maskQ[b]      = maskR;
    assign stickyQ[b]    = stickyR;
    assign latchQ[b]     = latchR;
    assign rawStat[b]    = (stickyR & latchR) | (~stickyR & lvl[b]);
    assign maskedStat[b] = rawStat[b] & ~maskR;
  end

  always_comb begin
    case (strb.rdSel)
      SEL_MSTAT:  rdByte = maskedStat[strb.rdBank];
      SEL_RSTAT:  rdByte = rawStat[strb.rdBank];
      SEL_MASK:   rdByte = maskQ[strb.rdBank];
      SEL_DIR:    rdByte = dirQ[strb.rdBank];
      SEL_OUT:    rdByte = outQ[strb.rdBank];
      SEL_IN:     rdByte = lvl[strb.rdBank];
      SEL_STICKY: rdByte = stickyQ[strb.rdBank];
      default:    rdByte = '0;
    endcase
  end

  assign pinOut     = outQ;
  assign pinOe      = ~dirQ;
  assign irqOut     = |maskedStat;
  assign maskState  = maskQ;
  assign latchState = latchQ;
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
  import banked_gpio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic              irqOut
);
  strobe_t                      strb;
  logic [BANK_W-1:0]            rdByte;
  logic [BANKS-1:0][BANK_W-1:0] maskState, latchState;
  logic                         unusedWdataHi;

  assign unusedWdataHi = ^regWdata[DATA_W-1:BANK_W];

  banked_gpio_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  banked_gpio_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrByte     (regWdata[BANK_W-1:0]),
    .pinIn      (pinIn),
    .rdByte     (rdByte),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .irqOut     (irqOut),
    .maskState  (maskState),
    .latchState (latchState)
  );

  assign regRdata = {{(DATA_W-BANK_W){1'b0}}, rdByte};
endmodule

// File: rtl/banked_gpio_chk.sv
module banked_gpio_chk
  import banked_gpio_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            regAddr,
  input logic                         regWe,
  input logic [BANK_W-1:0]            wrByte,
  input logic [DATA_W-1:0]            regRdata,
  input logic [PINS-1:0]              pinOe,
  input logic                         irqOut,
  input logic [BANKS-1:0][BANK_W-1:0] maskState,
  input logic [BANKS-1:0][BANK_W-1:0] latchState
);
  logic [OFF_W-1:0]             off;
  logic [BANK_IDX_W-1:0]        bank;
  logic [BANKS-1:0][BANK_W-1:0] oeBanks;
  logic                         mapped;

  assign off     = regAddr[OFF_W-1:0];
  assign bank    = regAddr[ADDR_W-1:OFF_W];
  assign oeBanks = pinOe;
  assign mapped  = (off == OFF_MSTAT) || (off == OFF_RSTAT) || (off == OFF_MSET) ||
                   (off == OFF_DIR) || (off == OFF_OUT) || (off == OFF_IN) ||
                   (off == OFF_STICKY);

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && off == OFF_MSET) |=>
      ((maskState[$past(bank)] & $past(wrByte)) == $past(wrByte)));

  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && off == OFF_MCLR) |=>
      ((maskState[$past(bank)] & $past(wrByte)) == '0));

  // R3
  dir_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && off == OFF_DIR) |=> (oeBanks[$past(bank)] == ~$past(wrByte)));

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && off == OFF_RSTAT) |=>
      ((latchState & $past(latchState)) == $past(latchState)));

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskState) |-> !irqOut);

  // R12
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (regRdata == '0));

  // R12
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:BANK_W] == '0);
endmodule

bind banked_gpio banked_gpio_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .regWe      (regWe),
  .wrByte     (regWdata[banked_gpio_pkg::BANK_W-1:0]),
  .regRdata   (regRdata),
  .pinOe      (pinOe),
  .irqOut     (irqOut),
  .maskState  (maskState),
  .latchState (latchState)
);

// File: tb/banked_gpio_bench.sv
module banked_gpio_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  regAddr;
  logic        regWe;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic [31:0] pinIn;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  banked_gpio u_banked_gpio (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // reference model built from the requirements
  logic [3:0][7:0] mDir, mOut, mMask, mSticky, mLatch;
  logic [31:0]     mS1, mS2, mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir <= '1; mOut <= '0; mMask <= '1; mSticky <= '0; mLatch <= '0;
      mS1 <= '0; mS2 <= '0; mPrev <= '0;
    end else begin
      mS1 <= pinIn; mS2 <= mS1; mPrev <= mS2;
      for (int b = 0; b < 4; b++) begin
        logic hit;
        logic [7:0] clr, rs;
        hit = regWe && (regAddr[7:6] == 2'(b));
        clr = (hit && regAddr[5:0] == 6'h04) ? regWdata[7:0] : 8'h00;
        rs  = mS2[b*8 +: 8] & ~mPrev[b*8 +: 8];
        mLatch[b] <= ((mLatch[b] & ~clr) | rs) & mSticky[b];
        if (hit) begin
          case (regAddr[5:0])
            6'h08: mMask[b]   <= mMask[b] | regWdata[7:0];
            6'h0C: mMask[b]   <= mMask[b] & ~regWdata[7:0];
            6'h10: mDir[b]    <= regWdata[7:0];
            6'h14: mOut[b]    <= regWdata[7:0];
            6'h20: mSticky[b] <= mSticky[b] | regWdata[7:0];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [7:0] rawOf(input int b);
    return (mSticky[b] & mLatch[b]) | (~mSticky[b] & mS2[b*8 +: 8]);
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    int b = int'(a[7:6]);
    case (a[5:0])
      6'h00: return {24'h0, rawOf(b) & ~mMask[b]};
      6'h04: return {24'h0, rawOf(b)};
      6'h08: return {24'h0, mMask[b]};
      6'h10: return {24'h0, mDir[b]};
      6'h14: return {24'h0, mOut[b]};
      6'h18: return {24'h0, mS2[b*8 +: 8]};
      6'h20: return {24'h0, mSticky[b]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic expIrq();
    logic r = 1'b0;
    for (int b = 0; b < 4; b++) r = r | (|(rawOf(b) & ~mMask[b]));
    return r;
  endfunction

  function automatic string reqOf(input logic [5:0] o);
    case (o)
      6'h00: return "R10";
      6'h04: return "R8";
      6'h08: return "R5";
      6'h0C: return "R6";
      6'h10: return "R3";
      6'h14: return "R3";
      6'h18: return "R4";
      6'h20: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input string req, input logic [31:0] exp);
    regAddr = a; regWe = 1'b0;
    #1;
    check(req, regRdata, exp);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [7:0] offs [10];
    offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h1C, 8'h3C};
    void'($urandom(32'd1234));
    rstN = 1'b0; regAddr = '0; regWe = 1'b0; regWdata = '0; pinIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    for (int b = 0; b < 4; b++) begin
      rdChk(8'(b*64) | 8'h10, "R2", 32'hFF);
      rdChk(8'(b*64) | 8'h08, "R2", 32'hFF);
      rdChk(8'(b*64) | 8'h14, "R2", 32'h0);
      rdChk(8'(b*64) | 8'h20, "R2", 32'h0);
      rdChk(8'(b*64) | 8'h04, "R2", 32'h0);
      rdChk(8'(b*64) | 8'h00, "R2", 32'h0);
    end
    check("R2", pinOe, 32'h0);
    check("R2", pinOut, 32'h0);
    check("R2", {31'h0, irqOut}, 32'h0);

    // R4 / R1 synchroniser latency, pin 8 is bank 1 bit 0
    @(negedge clk); pinIn = 32'h0000_0100;
    @(negedge clk); rdChk(8'h58, "R4", 32'h00);
    @(negedge clk); rdChk(8'h58, "R4", 32'h01);
    rdChk(8'h18, "R1", 32'h00);

    // R7 level status ignores clear writes
    rdChk(8'h44, "R7", 32'h01);
    wrReg(8'h44, 32'hFF);
    rdChk(8'h44, "R7", 32'h01);

    // R9 sticky set, zeros do not clear
    wrReg(8'h60, 32'h02);
    rdChk(8'h60, "R9", 32'h02);
    wrReg(8'h60, 32'h00);
    rdChk(8'h60, "R9", 32'h02);

    // R8 sticky latch on pin 9
    pinIn = 32'h0000_0300;
    @(negedge clk);
    @(negedge clk); rdChk(8'h44, "R8", 32'h01);
    @(negedge clk); rdChk(8'h44, "R8", 32'h03);
    pinIn = 32'h0000_0100;
    repeat (4) @(negedge clk);
    rdChk(8'h44, "R8", 32'h03);
    wrReg(8'h44, 32'h01);
    rdChk(8'h44, "R8", 32'h03);
    wrReg(8'h44, 32'h02);
    rdChk(8'h44, "R8", 32'h01);

    // R10 / R11 masking and interrupt line
    rdChk(8'h40, "R10", 32'h00);
    check("R11", {31'h0, irqOut}, 32'h0);
    wrReg(8'h4C, 32'h01);
    rdChk(8'h48, "R5", 32'hFE);
    rdChk(8'h40, "R10", 32'h01);
    check("R11", {31'h0, irqOut}, 32'h1);
    rdChk(8'h4C, "R6", 32'h00);
    wrReg(8'h40, 32'hFF);
    rdChk(8'h40, "R10", 32'h01);
    wrReg(8'h48, 32'h01);
    check("R11", {31'h0, irqOut}, 32'h0);

    // R3 direction and outputs, R12 unmapped offsets
    wrReg(8'hD0, 32'h0F);
    check("R3", {24'h0, pinOe[31:24]}, 32'hF0);
    wrReg(8'hD4, 32'hA5);
    check("R3", {24'h0, pinOut[31:24]}, 32'hA5);
    wrReg(8'hDC, 32'hFFFF_FFFF);
    rdChk(8'hDC, "R12", 32'h0);
    rdChk(8'hD0, "R12", 32'h0F);

    // seeded random traffic checked against the model
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] a;
      @(negedge clk);
      if ($urandom_range(0, 2) == 0) pinIn = $urandom;
      a = 8'($urandom_range(0, 3) * 64) | offs[$urandom_range(0, 9)];
      regAddr = a;
      regWe = ($urandom_range(0, 3) != 0);
      regWdata = $urandom;
      @(negedge clk);
      regWe = 1'b0;
      a = 8'($urandom_range(0, 3) * 64) | offs[$urandom_range(0, 9)];
      rdChk(a, reqOf(a[5:0]), expRead(a));
      check("R3", pinOut, mOut);
      check("R3", pinOe, ~mDir);
      check("R11", {31'h0, irqOut}, {31'h0, expIrq()});
    end

    done = 1'b1;
    finishRun();
  end
endmodule